// File: doc/BRIEF.md
# Burst Power-Amplifier Switch Sequencer

This block is the digital sequencer that steers the analog switches of a time-slotted power-amplifier control loop. Each transmit burst is framed by a power-up request. When the request rises, the block freezes the band choice and powers up the driver of the chosen band. It then runs a timed detector-sampling phase and waits in a ready phase for the ramp comparator to report the first DAC step. After that event it moves the control output from the pre-bias level to the home level. Once a short home interval has passed, it hands over to closed-loop operation.

The unused band is held safe for the whole burst: its driver is powered down, its feedback switch is open and its control output is forced to ground. When the request falls, the block returns within a few clocks to a disabled state. In that state both outputs are grounded and all phase state is cleared. All three inputs are asynchronous to the system clock. Each one passes through a two-flop synchroniser, so an input change shows up on the outputs on the third rising clock edge after it.

Top module: `pa_burst_seq`

## Requirements
- R1: The band input is captured when the block leaves the disabled phase on a power-up request and is held until the request falls; band input changes during a burst have no effect. Value 0 selects the low band (index 0 of every per-band output), value 1 the high band (index 1).
- R2: While a burst is active, only the selected band has its driver powered up and its force-low deasserted; the other band's driver is off, its feedback switch is open and its force-low is asserted.
- R3: On the third rising clock edge after the power-up input rises, the phase becomes sample: sampling switch, pre-bias switch and selected feedback switch closed (1), home and transfer switches open (0).
- R4: The sample phase lasts exactly SAMPLE_CYC clock cycles (default 2000, 16 us at 125 MHz). After that the phase becomes ready, with the sampling switch open and the pre-bias and selected feedback switches still closed.
- R5: A ramp flag seen in the ready phase moves the block to the home phase on the third rising edge after the ramp input rises. In that phase the pre-bias switch is open, the home switch is closed, the selected feedback switch is still closed, and the pre-bias and home switches are never closed together.
- R6: The home phase lasts exactly HOME_CYC cycles (default 250, 2 us). After that the phase becomes closed loop, with the selected feedback switch open and the transfer and home switches closed.
- R7: On the third rising edge after the power-up input falls, from any phase, the block is disabled. Both force-low outputs are 1, the sampling and pre-bias switches are closed, and the home switch, transfer switch, both feedback switches and both drivers are off.
- R8: The ramp input has no effect in the disabled, sample, home and closed-loop phases.
- R9: The phase output is encoded as 0 disabled, 1 sample, 2 ready, 3 home, 4 closed loop.
- R10: Synchronous active-high reset puts the block in the disabled phase with the low band latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up_i | input | 1 | Burst power-up request (asynchronous) |
| band_i | input | 1 | Band choice, 0 low, 1 high (asynchronous) |
| ramp_i | input | 1 | Ramp-step flag from the comparator (asynchronous) |
| smp_sw_o | output | 1 | Detector sampling switch closed |
| prebias_sw_o | output | 1 | Pre-bias switch closed |
| home_sw_o | output | 1 | Home switch closed |
| xfer_sw_o | output | 1 | Transfer switch closed |
| fb_sw_o | output | 2 | Per-band feedback switch closed |
| drv_pu_o | output | 2 | Per-band driver powered up |
| force_low_o | output | 2 | Per-band control output forced to ground |
| phase_o | output | 3 | Current phase code |

## Verification
Full bursts are run on both bands, so a swapped or unlatched band index shows up as the wrong driver, feedback switch or force-low bit. Each phase change is sampled one edge before and on the edge it is due. This separates an off-by-one in the synchroniser depth or in either timer from a correct count. Ramp pulses are also given in the disabled, sample, home and closed-loop phases, and the band input is flipped mid-burst; these runs show whether the ramp and band inputs are truly ignored outside their windows. Bursts cut short during home and during sample show that shutdown works from any phase and that the next burst latches its band afresh.

// File: rtl/pa_seq_pkg.sv
package pa_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SAMPLE = 3'd1,
        PH_READY  = 3'd2,
        PH_HOME   = 3'd3,
        PH_LOOP   = 3'd4
    } phase_e;

    localparam int NUM_BANDS = 2;

    typedef struct packed {
        logic                 smp;
        logic                 prebias;
        logic                 home;
        logic                 xfer;
        logic [NUM_BANDS-1:0] fb;
        logic [NUM_BANDS-1:0] drv;
        logic [NUM_BANDS-1:0] frc;
    } sw_t;

    function automatic logic phase_closes_prebias(phase_e ph);
        return (ph == PH_IDLE) || (ph == PH_SAMPLE) || (ph == PH_READY);
    endfunction

    function automatic logic phase_closes_home(phase_e ph);
        return (ph == PH_HOME) || (ph == PH_LOOP);
    endfunction

endpackage

// File: rtl/pa_sync2.sv
module pa_sync2 #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= d_i[i];
                s2_q <= s1_q;
            end
        end
        assign q_o[i] = s2_q;
    end
endmodule

// File: rtl/pa_seq_fsm.sv
module pa_seq_fsm
    import pa_seq_pkg::*;
#(
    parameter int SAMPLE_CYC = 2000,
    parameter int HOME_CYC   = 250
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pu_s,
    input  logic   band_s,
    input  logic   ramp_s,
    output phase_e phase_o,
    output logic   band_o
);
    localparam int MAXC = (SAMPLE_CYC > HOME_CYC) ? SAMPLE_CYC : HOME_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] SMP_LAST  = CW'(SAMPLE_CYC - 1);
    localparam logic [CW-1:0] HOME_LAST = CW'(HOME_CYC - 1);

    phase_e        phase_q, phase_d;
    logic [CW-1:0] cnt_q;
    logic          band_q;

    always_comb begin
        phase_d = phase_q;
        if (!pu_s) begin
            phase_d = PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:   phase_d = PH_SAMPLE;
                PH_SAMPLE: if (cnt_q == SMP_LAST)  phase_d = PH_READY;
                PH_READY:  if (ramp_s)             phase_d = PH_HOME;
                PH_HOME:   if (cnt_q == HOME_LAST) phase_d = PH_LOOP;
                PH_LOOP:   phase_d = PH_LOOP;
                default:   phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            band_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (phase_d != phase_q) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
            if (phase_q == PH_IDLE && pu_s) band_q <= band_s;
        end
    end

    assign phase_o = phase_q;
    assign band_o  = band_q;
endmodule

// File: rtl/pa_sw_decode.sv
module pa_sw_decode
    import pa_seq_pkg::*;
(
    input  phase_e phase_i,
    input  logic   band_i,
    output sw_t    sw_o
);
    logic active;
    assign active = (phase_i != PH_IDLE);

    always_comb begin
        sw_o.smp     = (phase_i == PH_IDLE) || (phase_i == PH_SAMPLE);
        sw_o.prebias = phase_closes_prebias(phase_i);
        sw_o.home    = phase_closes_home(phase_i);
        sw_o.xfer    = (phase_i == PH_LOOP);
    end

    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
        logic sel;
        assign sel         = active && (band_i == b[0]);
        assign sw_o.drv[b] = sel;
        assign sw_o.frc[b] = !sel;
        assign sw_o.fb[b]  = sel && (phase_i != PH_LOOP);
    end
endmodule

// File: rtl/pa_burst_seq.sv
module pa_burst_seq
    import pa_seq_pkg::*;
#(
    parameter int CLK_MHZ   = 125,
    parameter int SAMPLE_US = 16,
    parameter int HOME_US   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_up_i,
    input  logic       band_i,
    input  logic       ramp_i,
    output logic       smp_sw_o,
    output logic       prebias_sw_o,
    output logic       home_sw_o,
    output logic       xfer_sw_o,
    output logic [1:0] fb_sw_o,
    output logic [1:0] drv_pu_o,
    output logic [1:0] force_low_o,
    output logic [2:0] phase_o
);
    localparam int SAMPLE_CYC = CLK_MHZ * SAMPLE_US;
    localparam int HOME_CYC   = CLK_MHZ * HOME_US;

    logic [2:0] sync_q;
    phase_e     phase;
    logic       band_lat;
    sw_t        sw;

    pa_sync2 #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({ramp_i, band_i, pwr_up_i}),
        .q_o (sync_q)
    );

    pa_seq_fsm #(.SAMPLE_CYC(SAMPLE_CYC), .HOME_CYC(HOME_CYC)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pu_s    (sync_q[0]),
        .band_s  (sync_q[1]),
        .ramp_s  (sync_q[2]),
        .phase_o (phase),
        .band_o  (band_lat)
    );

    pa_sw_decode u_dec (
        .phase_i (phase),
        .band_i  (band_lat),
        .sw_o    (sw)
    );

    assign smp_sw_o     = sw.smp;
    assign prebias_sw_o = sw.prebias;
    assign home_sw_o    = sw.home;
    assign xfer_sw_o    = sw.xfer;
    assign fb_sw_o      = sw.fb;
    assign drv_pu_o     = sw.drv;
    assign force_low_o  = sw.frc;
    assign phase_o      = phase;
endmodule

// File: rtl/pa_burst_seq_chk.sv
module pa_burst_seq_chk
    import pa_seq_pkg::*;
#(
    parameter int SAMPLE_CYC = 2000,
    parameter int HOME_CYC   = 250
) (
    input logic       clk,
    input logic       rst,
    input logic       smp_sw,
    input logic       prebias_sw,
    input logic       home_sw,
    input logic       xfer_sw,
    input logic [1:0] fb_sw,
    input logic [1:0] drv_pu,
    input logic [1:0] force_low,
    input logic [2:0] phase
);
    logic [31:0] span_q;

    always_ff @(posedge clk) begin
        if (rst)                                         span_q <= '0;
        else if (phase == PH_SAMPLE || phase == PH_HOME) span_q <= span_q + 1;
        else                                             span_q <= '0;
    end

    AST_BAND_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(drv_pu)); // R1

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv_pu) && ((drv_pu & force_low) == 2'b00) && ((fb_sw & ~drv_pu) == 2'b00)); // R2

    AST_SAMPLE_LEN: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READY && $past(phase) == PH_SAMPLE) |-> span_q == 32'(SAMPLE_CYC)); // R4

    AST_HOME_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOME && $past(phase) != PH_HOME) |-> $past(phase) == PH_READY); // R5

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(prebias_sw && home_sw)); // R5

    AST_HOME_LEN: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOOP && $past(phase) == PH_HOME) |-> span_q == 32'(HOME_CYC)); // R6

    AST_LOOP_SWITCHES: assert property (@(posedge clk) disable iff (rst)
        xfer_sw |-> (home_sw && fb_sw == 2'b00 && !smp_sw)); // R6

    AST_IDLE_SAFE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (force_low == 2'b11 && smp_sw && prebias_sw && drv_pu == 2'b00)); // R7
endmodule

bind pa_burst_seq pa_burst_seq_chk #(
    .SAMPLE_CYC(SAMPLE_CYC),
    .HOME_CYC  (HOME_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_sw     (smp_sw_o),
    .prebias_sw (prebias_sw_o),
    .home_sw    (home_sw_o),
    .xfer_sw    (xfer_sw_o),
    .fb_sw      (fb_sw_o),
    .drv_pu     (drv_pu_o),
    .force_low  (force_low_o),
    .phase      (phase_o)
);

// File: tb/tb_pa_burst_seq.sv
`timescale 1ns/1ps
module tb_pa_burst_seq;
    localparam int SCYC = 2000;
    localparam int HCYC = 250;
    localparam int P_IDLE = 0, P_SMP = 1, P_RDY = 2, P_HOME = 3, P_LOOP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_up = 1'b0, band = 1'b0, ramp = 1'b0;
    logic smp_sw, prebias_sw, home_sw, xfer_sw;
    logic [1:0] fb_sw, drv_pu, force_low;
    logic [2:0] phase;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    pa_burst_seq dut (
        .clk(clk), .rst(rst), .pwr_up_i(pwr_up), .band_i(band), .ramp_i(ramp),
        .smp_sw_o(smp_sw), .prebias_sw_o(prebias_sw), .home_sw_o(home_sw),
        .xfer_sw_o(xfer_sw), .fb_sw_o(fb_sw), .drv_pu_o(drv_pu),
        .force_low_o(force_low), .phase_o(phase)
    );

    function automatic logic [12:0] expect_of(int ph, logic b);
        logic [1:0] sel;
        logic [1:0] fb;
        sel = (ph == P_IDLE) ? 2'b00 : (b ? 2'b10 : 2'b01);
        fb  = (ph == P_LOOP) ? 2'b00 : sel;
        return {3'(ph),
                1'(ph == P_IDLE || ph == P_SMP),
                1'(ph <= P_RDY),
                1'(ph >= P_HOME),
                1'(ph == P_LOOP),
                fb, sel, ~sel};
    endfunction

    function automatic logic [12:0] observed();
        return {phase, smp_sw, prebias_sw, home_sw, xfer_sw, fb_sw, drv_pu, force_low};
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int ph, logic b);
        logic [12:0] e, a;
        e = expect_of(ph, b);
        a = observed();
        tests++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s @%0t: actual=%h expected=%h", req, $time, a, e);
        end
    endtask

    task automatic set_pu(logic v);
        @(negedge clk); pwr_up = v;
    endtask

    task automatic set_ramp(logic v);
        @(negedge clk); ramp = v;
    endtask

    task automatic t_reset();
        rst = 1'b1; pwr_up = 0; band = 0; ramp = 0;
        tick(4);
        chk("R10 reset state", P_IDLE, 1'b0);
        @(negedge clk); rst = 1'b0;
        tick(3);
        chk("R7 idle after reset", P_IDLE, 1'b0);
    endtask

    // full burst on one band, every phase edge checked one cycle early and on time
    task automatic t_burst(logic b);
        @(negedge clk); band = b;
        set_pu(1'b1);
        tick(2); chk("R3 not before third edge", P_IDLE, b);
        tick(1); chk("R3 R2 R1 sample pattern", P_SMP, b);
        tick(SCYC - 1); chk("R4 still sample", P_SMP, b);
        tick(1); chk("R4 ready pattern", P_RDY, b);
        tick(5); chk("R5 ready waits for ramp", P_RDY, b);
        set_ramp(1'b1);
        tick(2); chk("R5 not before third edge", P_RDY, b);
        tick(1); chk("R5 home pattern", P_HOME, b);
        set_ramp(1'b0);
        tick(HCYC - 1); chk("R6 still home", P_HOME, b);
        tick(1); chk("R6 closed loop pattern", P_LOOP, b);
        @(negedge clk); band = ~b;
        tick(6); chk("R1 band change mid-burst ignored", P_LOOP, b);
        set_pu(1'b0);
        tick(2); chk("R7 loop held two edges", P_LOOP, b);
        tick(1); chk("R7 disabled after loop", P_IDLE, b);
        @(negedge clk); band = b;
    endtask

    task automatic t_ramp_ignored();
        set_ramp(1'b1); tick(4); set_ramp(1'b0); tick(3);
        chk("R8 ramp ignored while idle", P_IDLE, 1'b0);
        @(negedge clk); band = 1'b0;
        set_pu(1'b1);
        tick(3); chk("R3 sample entry", P_SMP, 1'b0);
        set_ramp(1'b1); tick(3); set_ramp(1'b0); tick(4);
        chk("R8 ramp ignored in sample", P_SMP, 1'b0);
        tick(SCYC - 8); chk("R8 R4 sample length unchanged", P_SMP, 1'b0);
        tick(1); chk("R4 ready after ramp-in-sample", P_RDY, 1'b0);
        tick(10); chk("R8 no late ramp effect", P_RDY, 1'b0);
        set_ramp(1'b1); tick(3); chk("R5 home entry", P_HOME, 1'b0);
        tick(20); chk("R8 held ramp in home no effect", P_HOME, 1'b0);
        set_ramp(1'b0);
        tick(HCYC - 21); chk("R6 home length with ramp", P_HOME, 1'b0);
        tick(1); chk("R6 loop entry", P_LOOP, 1'b0);
        set_ramp(1'b1); tick(5); set_ramp(1'b0); tick(4);
        chk("R8 ramp ignored in loop", P_LOOP, 1'b0);
        set_pu(1'b0); tick(3);
        chk("R7 disabled", P_IDLE, 1'b0);
    endtask

    task automatic t_abort();
        @(negedge clk); band = 1'b1;
        set_pu(1'b1);
        tick(3 + SCYC); chk("R4 ready on high band", P_RDY, 1'b1);
        set_ramp(1'b1); tick(3); set_ramp(1'b0);
        chk("R5 home on high band", P_HOME, 1'b1);
        tick(50);
        set_pu(1'b0);
        tick(2); chk("R7 home held before abort", P_HOME, 1'b1);
        tick(1); chk("R7 abort from home", P_IDLE, 1'b1);
        @(negedge clk); band = 1'b0;
        set_pu(1'b1);
        tick(3); chk("R1 relatch low band", P_SMP, 1'b0);
        tick(100);
        set_pu(1'b0);
        tick(3); chk("R7 abort from sample", P_IDLE, 1'b0);
        tick(5); chk("R9 R7 stays disabled", P_IDLE, 1'b0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        t_reset();
        t_burst(1'b0);
        t_burst(1'b1);
        t_ramp_ignored();
        t_abort();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule